// File: doc/BRIEF.md
# Floating-Point Issue Timing Scoreboard

This block tracks when floating-point operations may issue and when they finish, without computing any results. Requests arrive on a valid/ready handshake, each carrying an operation class, a destination register index and two source register indices. Add, multiply, conversion and compare classes go into a fully pipelined path. The four divide and square-root classes share one iterative unit. That unit refuses a new divide or square root until its occupancy window has run out, but pipelined work may issue around it.

A pending bit for each register makes issue wait while any register named by the request still has a result in flight. Every finished operation produces a one-cycle completion pulse carrying its destination index and class. There is a single writeback port. When the iterative unit and the pipeline finish in the same cycle, the iterative result takes the port. The whole pipeline then holds for one cycle, so the pipelined result appears one cycle later.

Top module: `fpu_sb_top`

## Requirements
- R1: While reset is active, `cmp_valid` is low. With all inputs at zero, `in_ready` is high.
- R2: Pipelined classes (encodings 0 add, 1 multiply, 2 convert, 3 compare) accept one request per cycle. Each completes exactly 4 cycles after the cycle in which it was accepted, with its destination and class on `cmp_dst` and `cmp_class`.
- R3: Single divide (class 4) completes 16 cycles after acceptance. The next divide or square root is accepted no earlier than 14 cycles after it.
- R4: Double divide (class 5) completes after 17 cycles and blocks the next iterative request for 15 cycles.
- R5: Single square root (class 6) completes after 24 cycles and blocks the next iterative request for 22 cycles.
- R6: Double square root (class 7) completes after 25 cycles and blocks the next iterative request for 23 cycles.
- R7: Pipelined requests are accepted back to back while the iterative unit is busy, and keep their 4-cycle latency.
- R8: A request whose destination or either source register is pending is held off. It is accepted in the cycle after the completion pulse for that register.
- R9: When an iterative result and a pipelined result are due in the same cycle, the iterative one is reported in that cycle. Every pipelined result in flight then slips by one cycle, and no pipelined request is accepted in the collision cycle.
- R10: Each accepted request yields exactly one completion pulse, and a pulse only ever names a register that is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_class | input | 3 | Operation class (0..3 pipelined, 4..7 iterative) |
| in_dst | input | 5 | Destination register index |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| cmp_valid | output | 1 | Completion pulse |
| cmp_dst | output | 5 | Destination of the completing operation |
| cmp_class | output | 3 | Class of the completing operation |

## Verification
A stale pending bit shows up as a request whose `in_ready` never returns. A lost pending bit shows up as a dependent request accepted before its producer's completion pulse. Both are visible within one latency of the producer. An occupancy counter loaded with the wrong value moves the acceptance cycle of a second iterative request, or the completion cycle of the first, by a fixed number of cycles. Faulty collision handling shows as two results whose completion cycles are off by one, or as a pipelined request accepted in the collision cycle.

// File: rtl/fpu_sb_pkg.sv
package fpu_sb_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_CVT   = 3'd2,
    OP_CMP   = 3'd3,
    OP_DIVS  = 3'd4,
    OP_DIVD  = 3'd5,
    OP_SQRTS = 3'd6,
    OP_SQRTD = 3'd7
  } op_cls_e;

  // occupancy (block) and completion (latency) figures of the iterative unit
  localparam int DIVS_BLK  = 14;
  localparam int DIVS_LAT  = 16;
  localparam int DIVD_BLK  = 15;
  localparam int DIVD_LAT  = 17;
  localparam int SQRTS_BLK = 22;
  localparam int SQRTS_LAT = 24;
  localparam int SQRTD_BLK = 23;
  localparam int SQRTD_LAT = 25;

  localparam int MAX_LAT = SQRTD_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  function automatic logic is_iter(input logic [2:0] c);
    return c[2];
  endfunction

  function automatic logic [CNT_W-1:0] blk_of(input logic [2:0] c);
    case (c)
      OP_DIVS:  return CNT_W'(DIVS_BLK);
      OP_DIVD:  return CNT_W'(DIVD_BLK);
      OP_SQRTS: return CNT_W'(SQRTS_BLK);
      OP_SQRTD: return CNT_W'(SQRTD_BLK);
      default:  return CNT_W'(0);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lat_of(input logic [2:0] c);
    case (c)
      OP_DIVS:  return CNT_W'(DIVS_LAT);
      OP_DIVD:  return CNT_W'(DIVD_LAT);
      OP_SQRTS: return CNT_W'(SQRTS_LAT);
      OP_SQRTD: return CNT_W'(SQRTD_LAT);
      default:  return CNT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/fpu_sb_pipe.sv
// Fixed-depth timing pipe for the pipelined classes; the whole pipe holds on stall.
module fpu_sb_pipe #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          in_v,
  input  logic [DW-1:0] in_data,
  output logic          out_v,
  output logic [DW-1:0] out_data
);

  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] v_d;
  logic [DW-1:0]    d_q [DEPTH];
  logic [DW-1:0]    d_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) begin
        v_d[i] = in_v;
        d_d[i] = in_data;
      end else begin
        v_d[i] = v_q[i-1];
        d_d[i] = d_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (!stall) begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!stall) begin
      for (int i = 0; i < DEPTH; i++) begin
        d_q[i] <= d_d[i];
      end
    end
  end

  assign out_v    = v_q[DEPTH-1];
  assign out_data = d_q[DEPTH-1];

endmodule

// File: rtl/fpu_sb_iter.sv
// Shared divide / square-root unit: an occupancy stage followed by a drain stage.
module fpu_sb_iter
  import fpu_sb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       start_cls,
  input  logic [IDX_W-1:0] start_dst,
  output logic             free,
  output logic             fire,
  output logic [IDX_W-1:0] fire_dst,
  output logic [2:0]       fire_cls
);

  logic             occ_v_q, occ_v_d;
  logic [CNT_W-1:0] occ_cnt_q, occ_cnt_d;
  logic [IDX_W-1:0] occ_dst_q, occ_dst_d;
  logic [2:0]       occ_cls_q, occ_cls_d;

  logic             drn_v_q, drn_v_d;
  logic [CNT_W-1:0] drn_cnt_q, drn_cnt_d;
  logic [IDX_W-1:0] drn_dst_q, drn_dst_d;
  logic [2:0]       drn_cls_q, drn_cls_d;

  logic occ_done;

  assign occ_done = occ_v_q && (occ_cnt_q == '0);
  assign free     = !occ_v_q || occ_done;
  assign fire     = drn_v_q && (drn_cnt_q == '0);
  assign fire_dst = drn_dst_q;
  assign fire_cls = drn_cls_q;

  always_comb begin
    occ_v_d   = occ_v_q;
    occ_cnt_d = occ_cnt_q;
    occ_dst_d = occ_dst_q;
    occ_cls_d = occ_cls_q;
    if (start) begin
      occ_v_d   = 1'b1;
      occ_cnt_d = blk_of(start_cls) - CNT_W'(1);
      occ_dst_d = start_dst;
      occ_cls_d = start_cls;
    end else if (occ_done) begin
      occ_v_d = 1'b0;
    end else if (occ_v_q) begin
      occ_cnt_d = occ_cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    drn_v_d   = drn_v_q;
    drn_cnt_d = drn_cnt_q;
    drn_dst_d = drn_dst_q;
    drn_cls_d = drn_cls_q;
    if (occ_done) begin
      drn_v_d   = 1'b1;
      drn_cnt_d = lat_of(occ_cls_q) - blk_of(occ_cls_q) - CNT_W'(1);
      drn_dst_d = occ_dst_q;
      drn_cls_d = occ_cls_q;
    end else if (fire) begin
      drn_v_d = 1'b0;
    end else if (drn_v_q) begin
      drn_cnt_d = drn_cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_v_q   <= 1'b0;
      occ_cnt_q <= '0;
      drn_v_q   <= 1'b0;
      drn_cnt_q <= '0;
    end else begin
      occ_v_q   <= occ_v_d;
      occ_cnt_q <= occ_cnt_d;
      drn_v_q   <= drn_v_d;
      drn_cnt_q <= drn_cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    occ_dst_q <= occ_dst_d;
    occ_cls_q <= occ_cls_d;
    drn_dst_q <= drn_dst_d;
    drn_cls_q <= drn_cls_d;
  end

endmodule

// File: rtl/fpu_sb_regtrack.sv
// Per-register in-flight bits and the issue hazard lookup.
module fpu_sb_regtrack #(
  parameter int NREG  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] look_a,
  input  logic [IDX_W-1:0] look_b,
  input  logic [IDX_W-1:0] look_c,
  output logic             hit,
  output logic [NREG-1:0]  pend
);

  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_idx] = 1'b0;
    if (set_en) pend_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (set_en || clr_en) begin
      pend_q <= pend_d;
    end
  end

  assign hit  = pend_q[look_a] | pend_q[look_b] | pend_q[look_c];
  assign pend = pend_q;

endmodule

// File: rtl/fpu_sb_top.sv
module fpu_sb_top
  import fpu_sb_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int PIPE_LAT = 4,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_class,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [IDX_W-1:0] in_src_a,
  input  logic [IDX_W-1:0] in_src_b,
  output logic             cmp_valid,
  output logic [IDX_W-1:0] cmp_dst,
  output logic [2:0]       cmp_class
);

  localparam int PDW = IDX_W + 3;

  logic             req_iter;
  logic             hazard;
  logic             accept;
  logic             iter_free;
  logic             drn_fire;
  logic [IDX_W-1:0] drn_dst;
  logic [2:0]       drn_cls;
  logic             pipe_last_v;
  logic [PDW-1:0]   pipe_last_d;
  logic             pipe_stall;
  logic [NREG-1:0]  pending;

  assign req_iter   = is_iter(in_class);
  assign pipe_stall = drn_fire && pipe_last_v;
  assign in_ready   = !hazard && (req_iter ? iter_free : !pipe_stall);
  assign accept     = in_valid && in_ready;

  fpu_sb_regtrack #(.NREG(NREG), .IDX_W(IDX_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept),
    .set_idx (in_dst),
    .clr_en  (cmp_valid),
    .clr_idx (cmp_dst),
    .look_a  (in_src_a),
    .look_b  (in_src_b),
    .look_c  (in_dst),
    .hit     (hazard),
    .pend    (pending)
  );

  fpu_sb_iter #(.IDX_W(IDX_W)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && req_iter),
    .start_cls (in_class),
    .start_dst (in_dst),
    .free      (iter_free),
    .fire      (drn_fire),
    .fire_dst  (drn_dst),
    .fire_cls  (drn_cls)
  );

  fpu_sb_pipe #(.DEPTH(PIPE_LAT), .DW(PDW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (pipe_stall),
    .in_v     (accept && !req_iter),
    .in_data  ({in_class, in_dst}),
    .out_v    (pipe_last_v),
    .out_data (pipe_last_d)
  );

  // writeback port: the iterative unit wins a tie
  always_comb begin
    cmp_valid = drn_fire || pipe_last_v;
    if (drn_fire) begin
      cmp_dst   = drn_dst;
      cmp_class = drn_cls;
    end else begin
      cmp_dst   = pipe_last_d[IDX_W-1:0];
      cmp_class = pipe_last_d[PDW-1:IDX_W];
    end
  end

endmodule

// File: rtl/fpu_sb_chk.sv
module fpu_sb_chk
  import fpu_sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_class,
  input logic [IDX_W-1:0] in_dst,
  input logic [IDX_W-1:0] in_src_a,
  input logic [IDX_W-1:0] in_src_b,
  input logic             cmp_valid,
  input logic [IDX_W-1:0] cmp_dst,
  input logic [2:0]       cmp_class,
  input logic [NREG-1:0]  pending,
  input logic             drn_fire,
  input logic             pipe_last_v
);

  logic             iter_take;
  logic             seen_q;
  logic [2:0]       last_cls_q;
  logic [CNT_W:0]   age_q;

  assign iter_take = in_valid && in_ready && in_class[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_cls_q <= 3'd0;
      age_q      <= '0;
    end else if (iter_take) begin
      seen_q     <= 1'b1;
      last_cls_q <= in_class;
      age_q      <= (CNT_W+1)'(1);
    end else if (age_q != '1) begin
      age_q <= age_q + (CNT_W+1)'(1);
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !cmp_valid);

  // R8
  issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !(pending[in_dst] || pending[in_src_a] || pending[in_src_b]));

  // R10
  cmp_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> pending[cmp_dst]);

  // R8
  cmp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !pending[$past(cmp_dst)]);

  // R9
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_fire && pipe_last_v) |=> (cmp_valid && !cmp_class[2]));

  // R3
  iter_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_take && seen_q) |-> (age_q >= {1'b0, blk_of(last_cls_q)}));

endmodule

bind fpu_sb_top fpu_sb_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_class    (in_class),
  .in_dst      (in_dst),
  .in_src_a    (in_src_a),
  .in_src_b    (in_src_b),
  .cmp_valid   (cmp_valid),
  .cmp_dst     (cmp_dst),
  .cmp_class   (cmp_class),
  .pending     (pending),
  .drn_fire    (drn_fire),
  .pipe_last_v (pipe_last_v)
);

// File: tb/fpu_sb_top_tb.sv
module fpu_sb_top_tb;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [2:0] in_class;
  logic [4:0] in_dst;
  logic [4:0] in_src_a;
  logic [4:0] in_src_b;
  logic       cmp_valid;
  logic [4:0] cmp_dst;
  logic [2:0] cmp_class;

  int cyc;
  int n_chk;
  int n_err;
  int n_log;
  int lg_cyc [256];
  int lg_dst [256];
  int lg_cls [256];

  fpu_sb_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_class  (in_class),
    .in_dst    (in_dst),
    .in_src_a  (in_src_a),
    .in_src_b  (in_src_b),
    .cmp_valid (cmp_valid),
    .cmp_dst   (cmp_dst),
    .cmp_class (cmp_class)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial n_log = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmp_valid === 1'b1 && n_log < 256) begin
      lg_cyc[n_log] = cyc;
      lg_dst[n_log] = int'(cmp_dst);
      lg_cls[n_log] = int'(cmp_class);
      n_log = n_log + 1;
    end
  end

  function automatic int exp_lat(input int c);
    if (c < 4) return 4;
    if (c == 4) return 16;
    if (c == 5) return 17;
    if (c == 6) return 24;
    return 25;
  endfunction

  function automatic int exp_blk(input int c);
    if (c == 4) return 14;
    if (c == 5) return 15;
    if (c == 6) return 22;
    return 23;
  endfunction

  function automatic string req_of(input int c);
    if (c < 4) return "R2";
    if (c == 4) return "R3";
    if (c == 5) return "R4";
    if (c == 6) return "R5";
    return "R6";
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // first logged completion for a destination; -1 when none
  task automatic find_first(input int dst, output int c, output int k);
    c = -1;
    k = -1;
    for (int i = n_log - 1; i >= 0; i--) begin
      if (lg_dst[i] == dst) begin
        c = lg_cyc[i];
        k = lg_cls[i];
      end
    end
  endtask

  // drive in the current cycle; returns one cycle after acceptance
  task automatic do_issue(input int c, input int d, input int sa, input int sb, output int icyc);
    in_valid = 1'b1;
    in_class = 3'(c);
    in_dst   = 5'(d);
    in_src_a = 5'(sa);
    in_src_b = 5'(sb);
    icyc     = -1;
    while (icyc < 0) begin
      @(negedge clk);
      if (in_ready === 1'b1) icyc = cyc;
      @(posedge clk);
      #2;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle_until(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err = n_err + 1;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    summary();
    $finish;
  end

  initial begin
    int a, b, cc, kk, t;
    int ib [4];
    n_chk    = 0;
    n_err    = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_class = 3'd0;
    in_dst   = 5'd0;
    in_src_a = 5'd0;
    in_src_b = 5'd0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "cmp_valid in reset", int'(cmp_valid), 0);
    check_eq("R1", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(posedge clk);
    #2;

    // R2..R6: latency and class of every class from idle
    for (int c = 0; c < 8; c++) begin
      n_log = 0;
      do_issue(c, c + 1, 0, 0, a);
      idle_until(a + 30);
      find_first(c + 1, cc, kk);
      check_eq(req_of(c), "latency", cc - a, exp_lat(c));
      check_eq(req_of(c), "class", kk, c);
      check_eq("R10", "one pulse per op", n_log, 1);
    end

    // R2: back-to-back pipelined burst
    n_log = 0;
    for (int i = 0; i < 4; i++) do_issue(i, 10 + i, 0, 0, ib[i]);
    idle_until(ib[3] + 8);
    for (int i = 0; i < 4; i++) begin
      check_eq("R2", "burst issue spacing", ib[i] - ib[0], i);
      find_first(10 + i, cc, kk);
      check_eq("R2", "burst latency", cc - ib[i], 4);
    end

    // R3..R6: occupancy window seen by a following single divide
    for (int c = 4; c < 8; c++) begin
      n_log = 0;
      do_issue(c, 20, 0, 0, a);
      do_issue(4, 21, 0, 0, b);
      idle_until(b + 20);
      check_eq(req_of(c), "iterative block", b - a, exp_blk(c));
      find_first(20, cc, kk);
      check_eq(req_of(c), "first completion", cc - a, exp_lat(c));
      find_first(21, cc, kk);
      check_eq("R3", "follower completion", cc - b, 16);
    end

    // R7: pipelined ops under a busy iterative unit
    n_log = 0;
    do_issue(7, 5, 0, 0, a);
    do_issue(0, 6, 0, 0, ib[0]);
    do_issue(1, 7, 0, 0, ib[1]);
    do_issue(3, 8, 0, 0, ib[2]);
    idle_until(a + 30);
    for (int i = 0; i < 3; i++) begin
      check_eq("R7", "issue while busy", ib[i] - a, i + 1);
      find_first(6 + i, cc, kk);
      check_eq("R7", "latency while busy", cc - ib[i], 4);
    end
    find_first(5, cc, kk);
    check_eq("R6", "sqrt with traffic", cc - a, 25);

    // R8: hazard sweep on source a, source b and destination
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 3; m++) begin
        int pc;
        pc = (p == 2) ? 4 : p * 2;
        n_log = 0;
        do_issue(pc, 9, 0, 0, a);
        if (m == 0) do_issue(0, 12, 9, 0, b);
        else if (m == 1) do_issue(0, 12, 0, 9, b);
        else do_issue(0, 9, 0, 0, b);
        idle_until(b + 8);
        find_first(9, cc, kk);
        check_eq("R8", "issue after release", b - cc, 1);
        check_eq("R8", "producer latency", cc - a, exp_lat(pc));
      end
    end

    // R9: writeback collision
    n_log = 0;
    do_issue(4, 1, 0, 0, t);
    idle_until(t + 11);
    do_issue(0, 2, 0, 0, ib[0]);
    do_issue(1, 3, 0, 0, ib[1]);
    do_issue(2, 4, 0, 0, ib[2]);
    idle_until(t + 16);
    do_issue(3, 5, 0, 0, ib[3]);
    idle_until(t + 30);
    check_eq("R9", "pre-collision issue", ib[0] - t, 11);
    check_eq("R9", "stalled issue cycle", ib[3] - t, 17);
    find_first(1, cc, kk);
    check_eq("R9", "divide wins port", cc - t, 16);
    find_first(2, cc, kk);
    check_eq("R9", "earlier pipelined result", cc - t, 15);
    find_first(3, cc, kk);
    check_eq("R9", "colliding result slips", cc - t, 17);
    find_first(4, cc, kk);
    check_eq("R9", "following result slips", cc - t, 18);
    find_first(5, cc, kk);
    check_eq("R9", "post-collision latency", cc - ib[3], 4);
    check_eq("R10", "pulses in collision test", n_log, 5);

    summary();
    $finish;
  end

endmodule